// File: doc/BRIEF.md
# Dual-Channel DAC Register Front End

This block is the digital side of a two-channel digital-to-analog converter. A host drives a byte-wide parallel bus with active-low strobes: chip select, write, load and clear. Each channel keeps two register stages. The first stage is a holding register that the host fills over the bus. The second stage is the output register that feeds the converter. Every control input is sampled by a system clock through a two-flop synchronizer, and a write is recognised at the rising edge of the write strobe.

Each channel's 12-bit code arrives in two writes. A low-byte write goes to a staging byte. A high-nibble write joins the nibble with that staged byte and commits the whole word, together with a gain bit and a reference-buffer bit, to the holding register. A commit marks the channel as pending. While the load strobe is low, a channel that is pending copies its holding register into its output register, and the pending mark is cleared. A channel that is not pending keeps its output untouched. With load held low, outputs follow each commit. With load high, the host can stage both channels and then release them together with a single pulse.

Top module: `dual_dac_frontend`

## Requirements
- R1: After the synchronous reset `rst`, both output codes read 0, and `gain_out` and `refbuf_out` read 0.
- R2: A write is taken when the synchronized `wr_n` rises while `cs_n` was low. `chan_sel` 0 selects channel A and 1 selects channel B. `byte_hi` 0 stores `data_in[7:0]` as code bits 7:0. `byte_hi` 1 supplies `data_in[3:0]` as code bits 11:8 and commits the word. A write with `cs_n` high changes nothing.
- R3: While `ldac_n` is high, the output code, gain and buffer bits of both channels hold their value, whatever is written.
- R4: The gain and buffer bits are captured by the high-nibble write. They reach `gain_out` and `refbuf_out` (bit 0 for channel A, bit 1 for channel B) only when that channel's word transfers.
- R5: An output register loads only when its channel has had a commit since its last load. A low-byte write alone never changes the output, even with `ldac_n` low.
- R6: Driving `clr_n` low clears all register stages of both channels at once, without waiting for a clock edge. This covers the staged low byte, the holding registers, the pending marks and the outputs.
- R7: With `ldac_n` held low, a committed word appears at the output without any other action on `ldac_n`.
- R8: When both channels are pending and `ldac_n` is pulsed low once, both output codes change on the same clock edge.
- R9: A commit that arrives in the same cycle as a transfer is not lost. The channel stays pending and loads the newer word on a following cycle, so the last committed word is what the output finally shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low clear of all register stages |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; the write happens on its rising edge |
| ldac_n | input | 1 | Active-low load strobe for the output registers |
| chan_sel | input | 1 | Channel select: 0 = A, 1 = B |
| byte_hi | input | 1 | 0 = low byte, 1 = high nibble plus commit |
| data_in | input | 8 | Parallel data bus |
| gain_in | input | 1 | Gain bit, captured with the high nibble |
| refbuf_in | input | 1 | Reference-buffer bit, captured with the high nibble |
| dac_code_a | output | 12 | Channel A output code |
| dac_code_b | output | 12 | Channel B output code |
| gain_out | output | 2 | Output-stage gain bits {B, A} |
| refbuf_out | output | 2 | Output-stage buffer bits {B, A} |

## Verification
The bench stages a low byte with load held low and checks that the output does not move. A design that transferred half-assembled words, or ignored the pending mark, would show a torn code there. It writes with chip select high and after a clear, which catches a design that lets a deselected write through or leaves the staged byte alive across a clear. It loads both channels with a single load pulse and compares the edges at which each output changes, which exposes a design that updates one channel late. It sends two commits back to back in follow mode to catch a design that drops the second commit when a write meets a transfer.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  parameter int CODE_W = 12;
  parameter int BYTE_W = 8;
  parameter int NUM_CH = 2;
  parameter int SYNC_STAGES = 2;
endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[i] <= rst_val;
          else     st[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[i] <= rst_val;
          else     st[i] <= st[i-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/dac_fe_channel.sv
module dac_fe_channel #(
  parameter int CODE_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] din,
  input  logic              gain_in,
  input  logic              refbuf_in,
  input  logic              ldac_act,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_gain,
  output logic              dac_refbuf
);
  localparam int HI_W = CODE_W - BYTE_W;

  logic [BYTE_W-1:0] lo_stage;
  logic [CODE_W-1:0] in_code;
  logic              in_gain, in_refbuf;
  logic              pend;
  logic              xfer;

  assign xfer = ldac_act & pend;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      lo_stage   <= '0;
      in_code    <= '0;
      in_gain    <= 1'b0;
      in_refbuf  <= 1'b0;
      pend       <= 1'b0;
      dac_code   <= '0;
      dac_gain   <= 1'b0;
      dac_refbuf <= 1'b0;
    end else if (rst) begin
      lo_stage   <= '0;
      in_code    <= '0;
      in_gain    <= 1'b0;
      in_refbuf  <= 1'b0;
      pend       <= 1'b0;
      dac_code   <= '0;
      dac_gain   <= 1'b0;
      dac_refbuf <= 1'b0;
    end else begin
      if (wr_lo) lo_stage <= din;
      if (wr_hi) begin
        in_code   <= {din[HI_W-1:0], lo_stage};
        in_gain   <= gain_in;
        in_refbuf <= refbuf_in;
      end
      if (xfer) begin
        dac_code   <= in_code;
        dac_gain   <= in_gain;
        dac_refbuf <= in_refbuf;
      end
      if (wr_hi)     pend <= 1'b1;
      else if (xfer) pend <= 1'b0;
    end
  end

  // R3: outputs frozen while the load strobe is inactive
  assert_hold_ldac_high_R3: assert property (@(posedge clk) disable iff (rst || !clr_n)
    !ldac_act |=> $stable({dac_code, dac_gain, dac_refbuf}));

  // R4 / R5: nothing reaches the output stage without a pending commit
  assert_no_load_without_pend_R5: assert property (@(posedge clk) disable iff (rst || !clr_n)
    !pend |=> $stable({dac_code, dac_gain, dac_refbuf}));

  // R9: a commit always leaves the channel pending
  assert_commit_not_lost_R9: assert property (@(posedge clk) disable iff (rst || !clr_n)
    wr_hi |=> pend);

  // R6: an active clear leaves every stage at zero
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (dac_code == '0 && !pend && lo_stage == '0 && !dac_gain && !dac_refbuf));
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
  import dac_fe_pkg::*;
#(
  parameter int P_CODE_W = CODE_W,
  parameter int P_BYTE_W = BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_n,
  input  logic                cs_n,
  input  logic                wr_n,
  input  logic                ldac_n,
  input  logic                chan_sel,
  input  logic                byte_hi,
  input  logic [P_BYTE_W-1:0] data_in,
  input  logic                gain_in,
  input  logic                refbuf_in,
  output logic [P_CODE_W-1:0] dac_code_a,
  output logic [P_CODE_W-1:0] dac_code_b,
  output logic [1:0]          gain_out,
  output logic [1:0]          refbuf_out
);
  localparam int NCH    = 2;
  localparam int CTRL_W = 7;
  localparam int BUS_W  = CTRL_W + P_BYTE_W;

  // bus layout: {cs_n, wr_n, ldac_n, chan_sel, byte_hi, gain, refbuf, data}
  logic [BUS_W-1:0] raw_bus, sync_bus, dly_bus, idle_bus;

  assign raw_bus  = {cs_n, wr_n, ldac_n, chan_sel, byte_hi, gain_in, refbuf_in, data_in};
  assign idle_bus = {3'b111, {(BUS_W-3){1'b0}}};

  dac_fe_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .rst_val(idle_bus), .q(sync_bus)
  );

  always_ff @(posedge clk) begin
    if (rst) dly_bus <= idle_bus;
    else     dly_bus <= sync_bus;
  end

  logic              s_wr_n, s_ldac_n;
  logic              d_cs_n, d_wr_n, d_sel, d_hi, d_gain, d_refbuf;
  logic [P_BYTE_W-1:0] d_data;

  assign s_wr_n   = sync_bus[BUS_W-2];
  assign s_ldac_n = sync_bus[BUS_W-3];
  assign d_cs_n   = dly_bus[BUS_W-1];
  assign d_wr_n   = dly_bus[BUS_W-2];
  assign d_sel    = dly_bus[BUS_W-4];
  assign d_hi     = dly_bus[BUS_W-5];
  assign d_gain   = dly_bus[BUS_W-6];
  assign d_refbuf = dly_bus[BUS_W-7];
  assign d_data   = dly_bus[P_BYTE_W-1:0];

  logic accept;
  assign accept = s_wr_n & ~d_wr_n & ~d_cs_n;

  logic [NCH-1:0]      wr_lo, wr_hi;
  logic [P_CODE_W-1:0] code_arr [NCH];
  logic [NCH-1:0]      gain_arr, refbuf_arr;
  logic                dly_ldac_unused;

  assign dly_ldac_unused = dly_bus[BUS_W-3];

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      assign wr_lo[c] = accept & (d_sel == 1'(c)) & ~d_hi;
      assign wr_hi[c] = accept & (d_sel == 1'(c)) &  d_hi;

      dac_fe_channel #(.CODE_W(P_CODE_W), .BYTE_W(P_BYTE_W)) u_ch (
        .clk(clk), .rst(rst), .clr_n(clr_n),
        .wr_lo(wr_lo[c]), .wr_hi(wr_hi[c]), .din(d_data),
        .gain_in(d_gain), .refbuf_in(d_refbuf), .ldac_act(~s_ldac_n),
        .dac_code(code_arr[c]), .dac_gain(gain_arr[c]), .dac_refbuf(refbuf_arr[c])
      );
    end
  endgenerate

  assign dac_code_a = code_arr[0];
  assign dac_code_b = code_arr[1];
  assign gain_out   = gain_arr;
  assign refbuf_out = refbuf_arr;

  // R2: at most one register strobe per accepted write
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst || !clr_n)
    $onehot0({wr_hi, wr_lo}));

  // R2: no strobe without a qualified write edge
  assert_strobe_needs_cs_R2: assert property (@(posedge clk) disable iff (rst || !clr_n)
    (|{wr_hi, wr_lo}) |-> (!d_cs_n && !d_wr_n));
endmodule

// File: tb/tb_dual_dac_frontend.sv
module tb_dual_dac_frontend;
  logic clk = 1'b0;
  logic rst = 1'b1, clr_n = 1'b1, cs_n = 1'b1, wr_n = 1'b1, ldac_n = 1'b1;
  logic chan_sel = 1'b0, byte_hi = 1'b0, gain_in = 1'b0, refbuf_in = 1'b0;
  logic [7:0]  data_in = '0;
  logic [11:0] dac_code_a, dac_code_b;
  logic [1:0]  gain_out, refbuf_out;

  int checks = 0, failures = 0;
  bit done = 0;
  int cyc = 0, chg_a = -1, chg_b = -1;
  logic [11:0] prev_a = '0, prev_b = '0;

  always #2.5 clk = ~clk;

  dual_dac_frontend dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n), .ldac_n(ldac_n),
    .chan_sel(chan_sel), .byte_hi(byte_hi), .data_in(data_in), .gain_in(gain_in),
    .refbuf_in(refbuf_in), .dac_code_a(dac_code_a), .dac_code_b(dac_code_b),
    .gain_out(gain_out), .refbuf_out(refbuf_out)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (dac_code_a !== prev_a) chg_a <= cyc;
    if (dac_code_b !== prev_b) chg_b <= cyc;
    prev_a <= dac_code_a;
    prev_b <= dac_code_b;
  end

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic ch, logic hi, logic [7:0] d, logic g, logic b, logic sel_n);
    @(negedge clk);
    chan_sel = ch; byte_hi = hi; data_in = d; gain_in = g; refbuf_in = b; cs_n = sel_n;
    @(negedge clk); wr_n = 1'b0;
    settle(3);
    wr_n = 1'b1;
    settle(3);
    cs_n = 1'b1;
  endtask

  task automatic word_write(logic ch, logic [11:0] w, logic g, logic b);
    bus_write(ch, 1'b0, w[7:0], 1'b0, 1'b0, 1'b0);
    bus_write(ch, 1'b1, {4'h0, w[11:8]}, g, b, 1'b0);
  endtask

  task automatic pulse_ldac();
    @(negedge clk); ldac_n = 1'b0;
    settle(4);
    ldac_n = 1'b1;
    settle(6);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_n = 1'b0;
    settle(2);
    clr_n = 1'b1;
    settle(2);
  endtask

  task automatic t_reset();
    chk("R1 code A", dac_code_a, 12'h000);
    chk("R1 code B", dac_code_b, 12'h000);
    chk("R1 gain/buf", {8'h0, gain_out, refbuf_out}, 12'h000);
  endtask

  task automatic t_async_mode();
    word_write(1'b0, 12'hA5C, 1'b1, 1'b0);
    settle(8);
    chk("R3 A held while load high", dac_code_a, 12'h000);
    chk("R4 gain not yet visible", {10'h0, gain_out}, 12'h000);
    pulse_ldac();
    chk("R2 A word assembled", dac_code_a, 12'hA5C);
    chk("R4 gain A after load", {10'h0, gain_out}, 12'h001);
    chk("R4 buf A after load", {10'h0, refbuf_out}, 12'h000);
    chk("R2 B untouched", dac_code_b, 12'h000);
  endtask

  task automatic t_cs_ignored();
    bus_write(1'b1, 1'b0, 8'h77, 1'b0, 1'b0, 1'b1);
    bus_write(1'b1, 1'b1, 8'h03, 1'b1, 1'b1, 1'b1);
    pulse_ldac();
    chk("R2 deselected write ignored", dac_code_b, 12'h000);
    chk("R2 deselected gain ignored", {10'h0, refbuf_out}, 12'h000);
  endtask

  task automatic t_simultaneous();
    word_write(1'b0, 12'h123, 1'b0, 1'b1);
    word_write(1'b1, 12'hFED, 1'b1, 1'b1);
    settle(6);
    chk("R3 A still old", dac_code_a, 12'hA5C);
    chk("R3 B still old", dac_code_b, 12'h000);
    pulse_ldac();
    chk("R8 A updated", dac_code_a, 12'h123);
    chk("R8 B updated", dac_code_b, 12'hFED);
    chk("R8 same edge", 12'(chg_a == chg_b), 12'h001);
    chk("R4 gain pair", {10'h0, gain_out}, 12'h002);
    chk("R4 buf pair", {10'h0, refbuf_out}, 12'h003);
  endtask

  task automatic t_sync_mode();
    @(negedge clk); ldac_n = 1'b0;
    settle(4);
    bus_write(1'b0, 1'b0, 8'hEE, 1'b0, 1'b0, 1'b0);
    settle(8);
    chk("R5 low byte alone no change", dac_code_a, 12'h123);
    bus_write(1'b0, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0);
    settle(6);
    chk("R7 follow mode update", dac_code_a, 12'h4EE);
    // back-to-back commits on channel B
    bus_write(1'b1, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0);
    bus_write(1'b1, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0);
    settle(6);
    chk("R9 last commit shown", dac_code_b, 12'h2ED);
    @(negedge clk); ldac_n = 1'b1;
    settle(4);
  endtask

  task automatic t_clear();
    pulse_clr();
    chk("R6 A cleared", dac_code_a, 12'h000);
    chk("R6 B cleared", dac_code_b, 12'h000);
    chk("R6 gain/buf cleared", {8'h0, gain_out, refbuf_out}, 12'h000);
    pulse_ldac();
    chk("R6 no pending after clear", dac_code_a, 12'h000);
    bus_write(1'b0, 1'b1, 8'h09, 1'b0, 1'b0, 1'b0);
    pulse_ldac();
    chk("R6 staged byte cleared", dac_code_a, 12'h900);
  endtask

  initial begin
    settle(4);
    rst = 1'b0;
    settle(2);
    t_reset();
    t_async_mode();
    t_cs_ignored();
    t_simultaneous();
    t_sync_mode();
    t_clear();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule